// File: doc/BRIEF.md
# Pixel-Pair YUV to RGBA Colour Converter

This block converts studio-range YUV samples into 32-bit RGBA pixels. Each accepted input is a group of two horizontally neighbouring 8-bit luma samples and the single U/V chroma pair that both of them share. The result is two packed RGBA words. The block takes a new group on every clock and returns the pair a fixed three cycles later, with a valid flag that travels alongside the data.

The arithmetic is exact integer arithmetic. Every intermediate value is kept within 16 unsigned bits. To stay inside that width, the datapath uses halving additions that keep the carry, additions and subtractions that saturate, and a final rounding shift that narrows each result to 8 bits. Green uses a shift of 7 and red and blue use a shift of 6. A video pipeline places the block after its line fetch and chroma pairing logic, and its outputs feed a frame writer.

Top module: `yuv_pair_rgba`

## Requirements
- R1: `out_valid` equals `in_valid` as it was three rising edges earlier. The pixel pair shown with it is derived from the group sampled on that same edge.
- R2: Bits [31:24] of both output words are always 8'hFF (alpha).
- R3: The red byte, in bits [7:0], is computed in steps. Let L = Y*149. Form H = (L + (V>>1) + V*204) >> 1 from a 17-bit sum. Subtract 14280 from H, flooring at 0. Then take (x+32)>>6 and clamp it to 255.
- R4: The green byte, in bits [15:8], is computed in steps. Add 17328 to Y*149, capping at 65535. Subtract U*50 + V*104, flooring at 0. Then take (x+64)>>7 and clamp it to 255.
- R5: The blue byte, in bits [23:16], is computed in steps. Form (Y*149 + U*4 + U*254) >> 1 from a 17-bit sum. Subtract 17704 from it, flooring at 0. Then take (x+32)>>6 and clamp it to 255.
- R6: Subtractions floor at zero instead of wrapping. Y=U=V=0 gives red 0 and blue 0. Y=0 with U=V=255 gives green 0.
- R7: Results above 255 clamp to 255. Y=U=V=255 gives red 255 and blue 255. Y=255 with U=V=0 gives green 255.
- R8: `out_pix0` is computed from `in_y0`, and `out_pix1` from `in_y1`. Both use the same U and V, so equal luma samples give equal words.
- R9: After one clock with `rst_n` low, `out_valid` is 0 and the R, G and B bytes of both words are 0.
- R10: A new group is accepted on every clock with `in_valid` high, with no gaps. Every accepted group produces exactly one output pair, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input group qualifier |
| in_y0 | input | 8 | Luma of the even (left) pixel |
| in_y1 | input | 8 | Luma of the odd (right) pixel |
| in_u | input | 8 | Shared U (blue-difference) chroma |
| in_v | input | 8 | Shared V (red-difference) chroma |
| out_valid | output | 1 | Output pair qualifier |
| out_pix0 | output | 32 | Even pixel: {A, B, G, R}, with R in bits [7:0] |
| out_pix1 | output | 32 | Odd pixel: {A, B, G, R}, with R in bits [7:0] |

## Verification
The checker assumes that the data inputs are stable and meaningful on every edge, whether or not `in_valid` is high. It also assumes that reset lasts at least one clock. This lets it tie outputs to inputs three edges back, once three clean cycles have passed since reset. The stimulus always drives defined values on Y, U and V, even during idle and reset cycles. It changes inputs only on falling edges and holds reset for several clocks. The stimulus includes:
- back-to-back bursts;
- a full V sweep at the Y and U extremes;
- random groups;
- directed groups whose exact bytes hit the floor and the clamp.

// File: rtl/yuv_rgba_pkg.sv
// Package for the YUV-pair to RGBA converter.
// Holds the widths, coefficients and offsets, the chroma product bundle, and
// the 16-bit unsigned helper functions (floor subtract, capped add, halving add).
// Assumes 8-bit samples and 16-bit intermediates throughout.
package yuv_rgba_pkg;

    localparam int PIX_W     = 8;
    localparam int ACC_W     = 16;
    localparam int NUM_LANES = 2;
    localparam int PIPE_LAT  = 3;

    localparam int LUMA_K = 149;
    localparam int RV_K   = 204;
    localparam int BU_K   = 254;
    localparam int GU_K   = 50;
    localparam int GV_K   = 104;

    localparam int RED_OFS = (16 * LUMA_K + 64 + 128 * RV_K) >> 1;
    localparam int GRN_OFS = -16 * LUMA_K + 128 * GU_K + 128 * GV_K;
    localparam int BLU_OFS = (16 * LUMA_K + 512 + 128 * BU_K) >> 1;

    localparam int RB_SHIFT = 6;
    localparam int G_SHIFT  = 7;

    localparam logic [PIX_W-1:0] ALPHA_BYTE = '1;

    typedef struct packed {
        logic [ACC_W-1:0] red_prod;
        logic [ACC_W-1:0] blu_prod;
        logic [ACC_W-1:0] grn_prod;
        logic [ACC_W-1:0] v_half;
        logic [ACC_W-1:0] u_x4;
    } chroma_t;

    // Unsigned subtract that stops at zero
    function automatic logic [ACC_W-1:0] sub_floor(input logic [ACC_W-1:0] a,
                                                   input logic [ACC_W-1:0] b);
        return (a >= b) ? (a - b) : '0;
    endfunction

    // Unsigned add that stops at the all-ones value
    function automatic logic [ACC_W-1:0] add_cap(input logic [ACC_W-1:0] a,
                                                 input logic [ACC_W-1:0] b);
        logic [ACC_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[ACC_W] ? '1 : s[ACC_W-1:0];
    endfunction

    // Halving add: carry is kept before the shift
    function automatic logic [ACC_W-1:0] add_half(input logic [ACC_W-1:0] a,
                                                  input logic [ACC_W-1:0] b);
        logic [ACC_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[ACC_W:1];
    endfunction

endpackage

// File: rtl/yuv_chroma_terms.sv
// Stage 1 chroma products shared by all lanes of a pair.
// Registers V*204, U*254, U*50+V*104, V>>1 and U<<2 as 16-bit values.
// Assumes 8-bit U and V, so every product fits 16 bits without loss.
module yuv_chroma_terms
    import yuv_rgba_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] u_in,
    input  logic [PIX_W-1:0] v_in,
    output chroma_t          terms_q
);

    logic [ACC_W-1:0] u_w;
    logic [ACC_W-1:0] v_w;
    chroma_t          terms_d;

    assign u_w = ACC_W'(u_in);
    assign v_w = ACC_W'(v_in);

    // Form all chroma products of the current group
    always_comb begin
        terms_d.red_prod = v_w * ACC_W'(RV_K);
        terms_d.blu_prod = u_w * ACC_W'(BU_K);
        terms_d.grn_prod = u_w * ACC_W'(GU_K) + v_w * ACC_W'(GV_K);
        terms_d.v_half   = v_w >> 1;
        terms_d.u_x4     = u_w << 2;
    end

    // Capture the chroma products into the stage 1 register
    always_ff @(posedge clk) begin
        if (!rst_n) terms_q <= '0;
        else        terms_q <= terms_d;
    end

endmodule

// File: rtl/yuv_luma_lane.sv
// One pixel lane covering stages 1 and 2.
// Stage 1 registers the luma product Y*149. Stage 2 merges it with the shared
// chroma products and produces the wide red, green and blue values before narrowing.
// Assumes chroma_q is the stage 1 register of the same group as y_in.
module yuv_luma_lane
    import yuv_rgba_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] y_in,
    input  chroma_t          chroma_q,
    output logic [ACC_W-1:0] red_q,
    output logic [ACC_W-1:0] grn_q,
    output logic [ACC_W-1:0] blu_q
);

    logic [ACC_W-1:0] luma_q;
    logic [ACC_W-1:0] red_d;
    logic [ACC_W-1:0] grn_d;
    logic [ACC_W-1:0] blu_d;

    // Register the scaled luma term
    always_ff @(posedge clk) begin
        if (!rst_n) luma_q <= '0;
        else        luma_q <= ACC_W'(y_in) * ACC_W'(LUMA_K);
    end

    // Combine luma and chroma with halving, capped and floored steps
    always_comb begin
        red_d = sub_floor(add_half(luma_q + chroma_q.v_half, chroma_q.red_prod),
                          ACC_W'(RED_OFS));
        grn_d = sub_floor(add_cap(luma_q, ACC_W'(GRN_OFS)), chroma_q.grn_prod);
        blu_d = sub_floor(add_half(luma_q + chroma_q.u_x4, chroma_q.blu_prod),
                          ACC_W'(BLU_OFS));
    end

    // Capture the wide colour values into the stage 2 register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            red_q <= '0;
            grn_q <= '0;
            blu_q <= '0;
        end else begin
            red_q <= red_d;
            grn_q <= grn_d;
            blu_q <= blu_d;
        end
    end

endmodule

// File: rtl/yuv_round_narrow.sv
// Stage 3 narrowing of one colour channel.
// Adds half of the shift step, shifts right by SHIFT and clamps to 8 bits,
// then registers the byte. Assumes 1 <= SHIFT < ACC_W.
module yuv_round_narrow
    import yuv_rgba_pkg::*;
#(
    parameter int SHIFT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] wide_in,
    output logic [PIX_W-1:0] byte_q
);

    localparam int SUM_W = ACC_W + 1;
    localparam int QUO_W = SUM_W - SHIFT;

    logic [SUM_W-1:0] rounded;
    logic [QUO_W-1:0] quot;
    logic [PIX_W-1:0] byte_d;

    // Round, shift and clamp to the byte range
    always_comb begin
        rounded = {1'b0, wide_in} + (SUM_W'(1) << (SHIFT - 1));
        quot    = rounded[SUM_W-1:SHIFT];
        byte_d  = (quot > QUO_W'(255)) ? '1 : quot[PIX_W-1:0];
    end

    // Register the narrowed byte
    always_ff @(posedge clk) begin
        if (!rst_n) byte_q <= '0;
        else        byte_q <= byte_d;
    end

endmodule

// File: rtl/yuv_pair_rgba.sv
// Top level of the YUV-pair to RGBA converter.
// Takes one luma pair and its shared U/V on each clock. Returns two packed
// {A,B,G,R} words three cycles later, with a matching valid flag.
// Assumes the data inputs hold defined values on every edge.
module yuv_pair_rgba
    import yuv_rgba_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_y0,
    input  logic [7:0]  in_y1,
    input  logic [7:0]  in_u,
    input  logic [7:0]  in_v,
    output logic        out_valid,
    output logic [31:0] out_pix0,
    output logic [31:0] out_pix1
);

    chroma_t             chroma_q;
    logic [PIX_W-1:0]    y_lane   [NUM_LANES];
    logic [4*PIX_W-1:0]  pix_lane [NUM_LANES];
    logic [PIPE_LAT-1:0] vld_pipe;

    assign y_lane[0] = in_y0;
    assign y_lane[1] = in_y1;

    yuv_chroma_terms u_chroma (
        .clk     (clk),
        .rst_n   (rst_n),
        .u_in    (in_u),
        .v_in    (in_v),
        .terms_q (chroma_q)
    );

    for (genvar li = 0; li < NUM_LANES; li++) begin : g_lane
        logic [ACC_W-1:0] red_w;
        logic [ACC_W-1:0] grn_w;
        logic [ACC_W-1:0] blu_w;
        logic [PIX_W-1:0] red_b;
        logic [PIX_W-1:0] grn_b;
        logic [PIX_W-1:0] blu_b;

        yuv_luma_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .y_in     (y_lane[li]),
            .chroma_q (chroma_q),
            .red_q    (red_w),
            .grn_q    (grn_w),
            .blu_q    (blu_w)
        );

        yuv_round_narrow #(.SHIFT(RB_SHIFT)) u_red (
            .clk (clk), .rst_n (rst_n), .wide_in (red_w), .byte_q (red_b)
        );
        yuv_round_narrow #(.SHIFT(G_SHIFT)) u_grn (
            .clk (clk), .rst_n (rst_n), .wide_in (grn_w), .byte_q (grn_b)
        );
        yuv_round_narrow #(.SHIFT(RB_SHIFT)) u_blu (
            .clk (clk), .rst_n (rst_n), .wide_in (blu_w), .byte_q (blu_b)
        );

        assign pix_lane[li] = {ALPHA_BYTE, blu_b, grn_b, red_b};
    end

    // Carry the valid flag alongside the data stages
    always_ff @(posedge clk) begin
        if (!rst_n) vld_pipe <= '0;
        else        vld_pipe <= {vld_pipe[PIPE_LAT-2:0], in_valid};
    end

    assign out_valid = vld_pipe[PIPE_LAT-1];
    assign out_pix0  = pix_lane[0];
    assign out_pix1  = pix_lane[1];

endmodule

// File: rtl/yuv_pair_rgba_chk.sv
// Checker for yuv_pair_rgba, attached by bind.
// Covers the valid latency, the reset state, the constant alpha and lane sharing.
// Assumes the data inputs are defined on every edge.
module yuv_pair_rgba_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [7:0]  in_y0,
    input logic [7:0]  in_y1,
    input logic        out_valid,
    input logic [31:0] out_pix0,
    input logic [31:0] out_pix1
);

    logic [1:0] run_cnt;
    logic [2:0] same_y_pipe;
    logic       prev_rst_low = 1'b0;

    // Count clean cycles since reset, stopping at three
    always_ff @(posedge clk) begin
        if (!rst_n)              run_cnt <= '0;
        else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end

    // Track the equal-luma condition of each group through three stages
    always_ff @(posedge clk) begin
        same_y_pipe <= {same_y_pipe[1:0], (in_y0 == in_y1)};
    end

    // Remember whether reset was low on the previous edge
    always_ff @(posedge clk) begin
        prev_rst_low <= !rst_n;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == 2'd3) |-> (out_valid == $past(in_valid, 3)));   // R1

    AST_ALPHA_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_pix0[31:24] == 8'hFF && out_pix1[31:24] == 8'hFF));   // R2

    AST_LANE_SHARE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == 2'd3 && out_valid && same_y_pipe[2]) |-> (out_pix0 == out_pix1));   // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        prev_rst_low |-> (!out_valid && out_pix0[23:0] == 24'd0 && out_pix1[23:0] == 24'd0));   // R9

endmodule

bind yuv_pair_rgba yuv_pair_rgba_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_y0     (in_y0),
    .in_y1     (in_y1),
    .out_valid (out_valid),
    .out_pix0  (out_pix0),
    .out_pix1  (out_pix1)
);

// File: tb/yuv_pair_rgba_tb_top.sv
// Self-checking bench for yuv_pair_rgba.
// A reference model built from the requirement equations predicts each pair,
// and a falling-edge monitor compares every output against a queue of predictions.
module yuv_pair_rgba_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_y0 = '0;
    logic [7:0]  in_y1 = '0;
    logic [7:0]  in_u = '0;
    logic [7:0]  in_v = '0;
    logic        out_valid;
    logic [31:0] out_pix0;
    logic [31:0] out_pix1;

    int checks = 0;
    int errors = 0;
    int tx_cnt = 0;
    int rx_cnt = 0;
    logic [31:0] exp_q0[$];
    logic [31:0] exp_q1[$];

    // Table of {y0, y1, u, v} groups, sent back to back
    localparam logic [31:0] VEC_TAB [12] = '{
        32'h10_10_80_80, 32'hEB_EB_80_80, 32'h51_5A_5A_F0, 32'h91_29_36_22,
        32'h29_91_F0_6E, 32'hD2_10_10_92, 32'h00_FF_80_80, 32'hFF_00_00_FF,
        32'h7F_80_7F_80, 32'h01_FE_02_FD, 32'h40_C0_C0_40, 32'hA5_5A_33_CC
    };

    always #5 clk = ~clk;

    yuv_pair_rgba dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_y0     (in_y0),
        .in_y1     (in_y1),
        .in_u      (in_u),
        .in_v      (in_v),
        .out_valid (out_valid),
        .out_pix0  (out_pix0),
        .out_pix1  (out_pix1)
    );

    // Reference pixel from the R3, R4 and R5 equations, packed {A,B,G,R}
    function automatic logic [31:0] ref_pix(input int y, input int u, input int v);
        int l, r, g, b;
        l = y * 149;
        r = (l + (v >> 1) + v * 204) >> 1;
        r = (r > 14280) ? r - 14280 : 0;
        r = (r + 32) >> 6;
        if (r > 255) r = 255;
        g = l + 17328;
        if (g > 65535) g = 65535;
        g = g - (u * 50 + v * 104);
        if (g < 0) g = 0;
        g = (g + 64) >> 7;
        if (g > 255) g = 255;
        b = (l + u * 4 + u * 254) >> 1;
        b = (b > 17704) ? b - 17704 : 0;
        b = (b + 32) >> 6;
        if (b > 255) b = 255;
        return {8'hFF, b[7:0], g[7:0], r[7:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // Compare each channel of one output word against its prediction
    task automatic check_word(input string lane, input logic [31:0] got, input logic [31:0] exp);
        check({"R3 red ", lane},   {24'd0, got[7:0]},   {24'd0, exp[7:0]});
        check({"R4 green ", lane}, {24'd0, got[15:8]},  {24'd0, exp[15:8]});
        check({"R5 blue ", lane},  {24'd0, got[23:16]}, {24'd0, exp[23:16]});
        check({"R2 alpha ", lane}, {24'd0, got[31:24]}, 32'hFF);
    endtask

    // Monitor: pop one prediction per valid output pair (R1, R8, R10)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            rx_cnt++;
            if (exp_q0.size() == 0) begin
                check("R10 unexpected output", 32'd1, 32'd0);
            end else begin
                check_word("pix0 R8", out_pix0, exp_q0.pop_front());
                check_word("pix1 R8", out_pix1, exp_q1.pop_front());
            end
        end
    end

    task automatic send(input logic [7:0] y0, input logic [7:0] y1,
                        input logic [7:0] u, input logic [7:0] v);
        @(negedge clk);
        in_valid = 1'b1;
        in_y0 = y0; in_y1 = y1; in_u = u; in_v = v;
        exp_q0.push_back(ref_pix(y0, u, v));
        exp_q1.push_back(ref_pix(y1, u, v));
        tx_cnt++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Single group with literal expected words and an exact latency count
    task automatic directed(input string req, input logic [7:0] y0, input logic [7:0] y1,
                            input logic [7:0] u, input logic [7:0] v,
                            input logic [31:0] e0, input logic [31:0] e1);
        send(y0, y1, u, v);
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 valid low after 1 cycle", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        check("R1 valid low after 2 cycles", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        check("R1 valid high after 3 cycles", {31'd0, out_valid}, 32'd1);
        check({req, " pix0"}, out_pix0, e0);
        check({req, " pix1"}, out_pix1, e1);
        idle(2);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Main sequence
    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset valid", {31'd0, out_valid}, 32'd0);
        check("R9 reset pix0", {8'd0, out_pix0[23:0]}, 32'd0);
        check("R9 reset pix1", {8'd0, out_pix1[23:0]}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // Table walk, back to back (R10)
        for (int i = 0; i < 12; i++)
            send(VEC_TAB[i][31:24], VEC_TAB[i][23:16], VEC_TAB[i][15:8], VEC_TAB[i][7:0]);
        idle(5);

        // Full V sweep at the Y and U extremes (R6, R7)
        for (int yu = 0; yu < 4; yu++)
            for (int v = 0; v < 256; v++)
                send((yu & 1) ? 8'hFF : 8'h00, (yu & 1) ? 8'h00 : 8'hFF,
                     (yu & 2) ? 8'hFF : 8'h00, 8'(v));
        idle(5);

        // Random groups with occasional gaps
        for (int i = 0; i < 2000; i++) begin
            if (($urandom % 8) == 0) idle(1);
            send(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
        end
        idle(5);

        // Directed corners with hand-derived words
        directed("R6 floor red/blue", 8'h00, 8'h00, 8'h00, 8'h00, 32'hFF008700, 32'hFF008700);
        directed("R6 floor green",    8'h00, 8'h00, 8'hFF, 8'hFF, 32'hFFED00B8, 32'hFFED00B8);
        directed("R7 clamp red/blue", 8'hFF, 8'hFF, 8'hFF, 8'hFF, 32'hFFFF7DFF, 32'hFFFF7DFF);
        directed("R8 lane split",     8'h00, 8'hFF, 8'h00, 8'h00, 32'hFF008700, 32'hFF14FF4A);

        check("R10 pair count", rx_cnt, tx_cnt);

        // Reset in the middle of a burst (R9)
        for (int i = 0; i < 4; i++) send(8'hEB, 8'h10, 8'(i * 40), 8'hC0);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        exp_q0.delete();
        exp_q1.delete();
        @(negedge clk);
        check("R9 mid reset valid", {31'd0, out_valid}, 32'd0);
        check("R9 mid reset pix0", {8'd0, out_pix0[23:0]}, 32'd0);
        check("R9 mid reset pix1", {8'd0, out_pix1[23:0]}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(4);
        check("R1 no output after reset", {31'd0, out_valid}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule